// File: doc/BRIEF.md
# Turn Indicator and Hazard Flasher Controller

This block drives the left and right indicator lamps of a vehicle from the raw levels of the turn stalk, the hazard button, a steering-return cancel sensor, an opposite-direction cancel sensor, and the engine and brake switches. Each input is registered, and the block acts on a change between two successive samples rather than on the level alone. A hazard press therefore toggles hazard mode once, and one pass of the cancel actuator clears the turn once.

One flash timer, advanced by a periodic `tick` strobe, serves both hazard mode and turn mode. The lamps are lit for a longer period than they are dark, and they light at once when flashing starts from rest. An inactivity timer, also counted in ticks, runs while the engine is off. It is reloaded by any change of the engine, hazard or brake inputs. When it runs out, the block raises a sleep request and turns both lamps off.

Top module: `turn_flasher`

## Requirements
- R1: After reset both lamps are off and `sleep_req` is low.
- R2: Every switch input is registered, and the block compares each sample with the previous one. A hazard or cancel input held at a constant level causes no further action after the first change.
- R3: Hazard mode inverts on each change of the sampled hazard input from 0 to 1. A release, or a press that is held, leaves hazard mode unchanged.
- R4: When only the left stalk input (or only the right) is sampled high, the turn state becomes that side. The turn state stays latched after the stalk is released.
- R5: When both stalk inputs are high at the same time, the existing turn state is kept.
- R6: Any change (rising or falling) of the sampled cancel input clears the turn state.
- R7: While the opposite-direction cancel input is high, the turn state is cleared and the stalk inputs are ignored.
- R8: While flashing, the lit phase lasts `LIT_TICKS` ticks and the dark phase lasts `DARK_TICKS` ticks, alternating.
- R9: While neither hazard nor a turn is active, the phase is held dark and the timer is held at the lit period. In the cycle after a source becomes active from rest, the phase goes lit with no dark delay.
- R10: In hazard mode both lamps follow the phase. Otherwise only the lamp of the latched turn side follows the phase. With nothing active, both lamps are off.
- R11: The inactivity timer loads `TIMEOUT_TICKS` on any change of the engine, hazard or brake input. It counts down one per tick while the engine input is low. At zero it holds `sleep_req` high and forces both lamps off until the next reload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle timebase strobe for both timers |
| stalk_left | input | 1 | Raw left turn request |
| stalk_right | input | 1 | Raw right turn request |
| hazard_btn | input | 1 | Raw hazard push button |
| cancel_sense | input | 1 | Raw steering-return cancel sensor |
| opp_cancel | input | 1 | Raw opposite-direction cancel sensor |
| engine_on | input | 1 | Raw engine running level |
| brake_on | input | 1 | Raw brake pedal level |
| lamp_left | output | 1 | Left indicator lamp drive |
| lamp_right | output | 1 | Right indicator lamp drive |
| sleep_req | output | 1 | Low-power shutdown request |

## Verification
Directed sequences hold ticks off, so that each latching rule can be seen apart from flash timing:
- a stalk pressed and released, which separates latching from level-following;
- both stalks pressed together, which separates keep from override;
- a hazard press held for many cycles, which separates edge toggling from level toggling;
- a cancel pulse with two edges;
- stalk input during an opposite-direction cancel.

Single tick pulses then measure the exact lit and dark lengths and the timeout boundary, one tick before and at expiry, and a brake change must wake the block. A long random phase then mixes sparse switch changes with an irregular tick against a bench model. This exercises a direct left-to-right switch, hazard mode on top of a turn, and timeout during flashing.

// File: rtl/turn_flasher_pkg.sv
package turn_flasher_pkg;

    // Sampled switch set, one bit per physical input
    typedef struct packed {
        logic brake;
        logic engine;
        logic opp;
        logic cancel;
        logic hazard;
        logic right;
        logic left;
    } sw_t;

    typedef enum logic [1:0] {
        TURN_NONE  = 2'd0,
        TURN_LEFT  = 2'd1,
        TURN_RIGHT = 2'd2
    } turn_e;

endpackage

// File: rtl/tf_sampler.sv
module tf_sampler
    import turn_flasher_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  sw_t  raw,
    output sw_t  level,
    output sw_t  change
);
    typedef struct packed {
        sw_t cur;
        sw_t prev;
    } smp_t;

    smp_t smp_d, smp_q;

    always_comb begin
        smp_d      = smp_q;
        smp_d.cur  = raw;
        smp_d.prev = smp_q.cur;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) smp_q <= '0;
        else        smp_q <= smp_d;
    end

    assign level  = smp_q.cur;
    assign change = smp_q.cur ^ smp_q.prev;

    // a level held steady produces no change on the following cycle
    AST_HELD_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (raw == level) |=> (change == '0)) else $error("held input changed"); // R2

endmodule

// File: rtl/tf_flash_timer.sv
module tf_flash_timer #(
    parameter int LIT_TICKS  = 16,
    parameter int DARK_TICKS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic active,
    output logic lit
);
    localparam int MAXP = (LIT_TICKS > DARK_TICKS) ? LIT_TICKS : DARK_TICKS;
    localparam int CW   = $clog2(MAXP + 1);
    localparam logic [CW-1:0] LIT_LD  = CW'(LIT_TICKS);
    localparam logic [CW-1:0] DARK_LD = CW'(DARK_TICKS);

    typedef struct packed {
        logic          act;
        logic          lit;
        logic [CW-1:0] cnt;
    } fl_t;

    fl_t fl_d, fl_q;

    always_comb begin
        fl_d     = fl_q;
        fl_d.act = active;
        if (!active) begin
            fl_d.lit = 1'b0;
            fl_d.cnt = LIT_LD;
        end else if (!fl_q.act) begin
            fl_d.lit = 1'b1;
        end else if (tick) begin
            if (fl_q.cnt <= 1) begin
                fl_d.lit = !fl_q.lit;
                fl_d.cnt = fl_q.lit ? DARK_LD : LIT_LD;
            end else begin
                fl_d.cnt = fl_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_q.act <= 1'b0;
            fl_q.lit <= 1'b0;
            fl_q.cnt <= LIT_LD;
        end else begin
            fl_q <= fl_d;
        end
    end

    assign lit = fl_q.lit;

    AST_START_LIT: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !fl_q.act) |=> fl_q.lit) else $error("no immediate flash"); // R9
    AST_REST_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (!fl_q.lit && fl_q.cnt == LIT_LD)) else $error("rest not dark"); // R9
    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        fl_q.act |-> (fl_q.cnt != 0 && fl_q.cnt <= CW'(MAXP))) else $error("flash count range"); // R8

endmodule

// File: rtl/tf_idle_timer.sv
module tf_idle_timer #(
    parameter int TIMEOUT_TICKS = 9155
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic reload,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(TIMEOUT_TICKS + 1);
    localparam logic [CW-1:0] TO_LD = CW'(TIMEOUT_TICKS);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (reload)                         cnt_d = TO_LD;
        else if (tick && run && cnt_q != 0) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= TO_LD;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

    AST_RELOAD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (cnt_q == TO_LD)) else $error("reload missed"); // R11
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!reload && !run) |=> $stable(cnt_q)) else $error("timer ran with engine on"); // R11

endmodule

// File: rtl/turn_flasher.sv
module turn_flasher
    import turn_flasher_pkg::*;
#(
    parameter int LIT_TICKS     = 16,
    parameter int DARK_TICKS    = 8,
    parameter int TIMEOUT_TICKS = 9155
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic stalk_left,
    input  logic stalk_right,
    input  logic hazard_btn,
    input  logic cancel_sense,
    input  logic opp_cancel,
    input  logic engine_on,
    input  logic brake_on,
    output logic lamp_left,
    output logic lamp_right,
    output logic sleep_req
);
    typedef struct packed {
        logic  hazard;
        turn_e turn;
    } st_t;

    sw_t  raw, lvl, chg;
    st_t  st_d, st_q;
    logic active, phase_lit, expired, reload, haz_press;

    always_comb begin
        raw        = '0;
        raw.left   = stalk_left;
        raw.right  = stalk_right;
        raw.hazard = hazard_btn;
        raw.cancel = cancel_sense;
        raw.opp    = opp_cancel;
        raw.engine = engine_on;
        raw.brake  = brake_on;
    end

    tf_sampler u_smp (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    (raw),
        .level  (lvl),
        .change (chg)
    );

    assign haz_press = chg.hazard && lvl.hazard;

    always_comb begin
        st_d = st_q;
        if (haz_press) st_d.hazard = !st_q.hazard;
        if (lvl.opp || chg.cancel)        st_d.turn = TURN_NONE;
        else if (lvl.left && !lvl.right)  st_d.turn = TURN_LEFT;
        else if (lvl.right && !lvl.left)  st_d.turn = TURN_RIGHT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.hazard <= 1'b0;
            st_q.turn   <= TURN_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign active = st_q.hazard || (st_q.turn != TURN_NONE);
    assign reload = chg.engine || chg.hazard || chg.brake;

    tf_flash_timer #(
        .LIT_TICKS  (LIT_TICKS),
        .DARK_TICKS (DARK_TICKS)
    ) u_flash (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .active (active),
        .lit    (phase_lit)
    );

    tf_idle_timer #(
        .TIMEOUT_TICKS (TIMEOUT_TICKS)
    ) u_idle (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .reload  (reload),
        .run     (!lvl.engine),
        .expired (expired)
    );

    assign lamp_left  = phase_lit && !expired && (st_q.hazard || st_q.turn == TURN_LEFT);
    assign lamp_right = phase_lit && !expired && (st_q.hazard || st_q.turn == TURN_RIGHT);
    assign sleep_req  = expired;

    AST_HAZ_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        haz_press |=> (st_q.hazard != $past(st_q.hazard))) else $error("hazard not toggled"); // R3
    AST_HAZ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !haz_press |=> $stable(st_q.hazard)) else $error("hazard changed without press"); // R3
    AST_CANCEL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        chg.cancel |=> (st_q.turn == TURN_NONE)) else $error("cancel ignored"); // R6
    AST_OPP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        lvl.opp |=> (st_q.turn == TURN_NONE)) else $error("opposite cancel ignored"); // R7
    AST_BOTH_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl.left && lvl.right && !lvl.opp && !chg.cancel) |=> $stable(st_q.turn)) else $error("both stalks changed turn"); // R5
    AST_ONE_LAMP_TURN: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.hazard |-> !(lamp_left && lamp_right)) else $error("two lamps in turn mode"); // R10

endmodule

// File: tb/turn_flasher_test.sv
module turn_flasher_test;
    localparam int LIT = 4;
    localparam int DRK = 2;
    localparam int TO  = 30;
    localparam int WATCHDOG = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    // bit order: 0 left, 1 right, 2 hazard, 3 cancel, 4 opp, 5 engine, 6 brake
    logic [6:0] sw = 7'b0;
    logic lamp_left, lamp_right, sleep_req;

    int checks = 0;
    int fails  = 0;
    bit compare_on = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    turn_flasher #(
        .LIT_TICKS     (LIT),
        .DARK_TICKS    (DRK),
        .TIMEOUT_TICKS (TO)
    ) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .stalk_left   (sw[0]),
        .stalk_right  (sw[1]),
        .hazard_btn   (sw[2]),
        .cancel_sense (sw[3]),
        .opp_cancel   (sw[4]),
        .engine_on    (sw[5]),
        .brake_on     (sw[6]),
        .lamp_left    (lamp_left),
        .lamp_right   (lamp_right),
        .sleep_req    (sleep_req)
    );

    // ---- reference model built from the requirements ----
    logic [6:0] m_cur, m_prev, m_chg;
    logic       m_haz, m_act, m_lit;
    logic [1:0] m_turn;            // 0 none, 1 left, 2 right
    int         m_fcnt, m_icnt;

    always_comb m_chg = m_cur ^ m_prev;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cur <= '0; m_prev <= '0; m_haz <= 1'b0; m_turn <= 2'd0;
            m_act <= 1'b0; m_lit <= 1'b0; m_fcnt <= LIT; m_icnt <= TO;
        end else begin
            m_cur  <= sw;
            m_prev <= m_cur;
            if (m_chg[2] && m_cur[2]) m_haz <= !m_haz;
            if (m_cur[4] || m_chg[3])      m_turn <= 2'd0;
            else if (m_cur[0] && !m_cur[1]) m_turn <= 2'd1;
            else if (m_cur[1] && !m_cur[0]) m_turn <= 2'd2;
            m_act <= m_haz || (m_turn != 0);
            if (!(m_haz || m_turn != 0)) begin
                m_lit <= 1'b0; m_fcnt <= LIT;
            end else if (!m_act) begin
                m_lit <= 1'b1;
            end else if (tick) begin
                if (m_fcnt <= 1) begin
                    m_lit <= !m_lit; m_fcnt <= m_lit ? DRK : LIT;
                end else m_fcnt <= m_fcnt - 1;
            end
            if (m_chg[5] || m_chg[2] || m_chg[6]) m_icnt <= TO;
            else if (tick && !m_cur[5] && m_icnt != 0) m_icnt <= m_icnt - 1;
        end
    end

    function automatic logic exp_lamp(input logic right_side);
        if (m_icnt == 0 || !m_lit) return 1'b0;
        return m_haz || (m_turn == (right_side ? 2'd2 : 2'd1));
    endfunction

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic lamps(input string req, input logic l, input logic r);
        check(req, "lamp_left", lamp_left, l);
        check(req, "lamp_right", lamp_right, r);
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        repeat (n) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
        end
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        #(WATCHDOG * 10);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20130708));
        sw[5] = 1'b1;                       // engine on: idle timer frozen
        cyc(3);
        @(negedge clk) rst_n = 1'b1;
        cyc(1);
        lamps("R1", 1'b0, 1'b0);
        check("R1", "sleep_req", sleep_req, 1'b0);

        // left latched, lights at once with no tick
        sw[0] = 1'b1; cyc(2); sw[0] = 1'b0; cyc(4);
        lamps("R4", 1'b1, 1'b0);            // R9 immediate lit
        // both stalks: keep left
        sw[1:0] = 2'b11; cyc(5);
        lamps("R5", 1'b1, 1'b0);
        sw[1:0] = 2'b00; cyc(3);
        // direct switch to right
        sw[1] = 1'b1; cyc(2); sw[1] = 1'b0; cyc(4);
        lamps("R4", 1'b0, 1'b1);
        // cancel pulse clears
        sw[3] = 1'b1; cyc(2); sw[3] = 1'b0; cyc(5);
        lamps("R6", 1'b0, 1'b0);
        // opposite-direction cancel clears and masks stalk
        sw[0] = 1'b1; cyc(2); sw[0] = 1'b0; cyc(4);
        lamps("R4", 1'b1, 1'b0);
        sw[4] = 1'b1; cyc(5);
        lamps("R7", 1'b0, 1'b0);
        sw[1] = 1'b1; cyc(5);
        lamps("R7", 1'b0, 1'b0);
        sw[1] = 1'b0; cyc(2); sw[4] = 1'b0; cyc(5);
        lamps("R7", 1'b0, 1'b0);
        // hazard press held long: single toggle
        sw[2] = 1'b1; cyc(6);
        lamps("R3", 1'b1, 1'b1);            // R10 both lamps
        cyc(12);
        lamps("R2", 1'b1, 1'b1);
        sw[2] = 1'b0; cyc(5);
        lamps("R3", 1'b1, 1'b1);
        // flash timing
        ticks(LIT - 1);
        lamps("R8", 1'b1, 1'b1);
        ticks(1);
        lamps("R8", 1'b0, 1'b0);
        ticks(DRK - 1);
        lamps("R8", 1'b0, 1'b0);
        ticks(1);
        lamps("R8", 1'b1, 1'b1);
        // second press turns hazard off, phase forced dark
        sw[2] = 1'b1; cyc(2); sw[2] = 1'b0; cyc(5);
        lamps("R3", 1'b0, 1'b0);
        ticks(3);
        lamps("R9", 1'b0, 1'b0);
        // inactivity timeout with hazard running
        sw[5] = 1'b0; cyc(4);
        sw[2] = 1'b1; cyc(2); sw[2] = 1'b0; cyc(4);
        ticks(TO - 1);
        check("R11", "sleep_req", sleep_req, 1'b0);
        ticks(1);
        check("R11", "sleep_req", sleep_req, 1'b1);
        lamps("R11", 1'b0, 1'b0);
        ticks(4);
        check("R11", "sleep_req", sleep_req, 1'b1);
        sw[6] = 1'b1; cyc(3);
        check("R11", "sleep_req", sleep_req, 1'b0);

        // random phase against the model
        compare_on = 1'b1;
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            check("R10", "lamp_left", lamp_left, exp_lamp(1'b0));
            check("R10", "lamp_right", lamp_right, exp_lamp(1'b1));
            check("R11", "sleep_req", sleep_req, (m_icnt == 0));
            tick = ($urandom % 3) == 0;
            for (int b = 0; b < 7; b++) begin
                int lim;
                lim = (b == 5) ? 200 : 24;
                if (($urandom % lim) == 0) sw[b] = !sw[b];
            end
        end
        finish_run();
    end
endmodule